// File: doc/BRIEF.md
# Interlaced Composite Frame Timing Sequencer

This block lays out the timing of a 525-line interlaced composite video frame. It counts clocks of a reference that runs at sixteen times the colour subcarrier, which is about 57.27 MHz. It tells the downstream pixel fetch and DAC logic what the line is doing at each clock. The output is a segment code that names one of five segments: sync tip, blanking level, colour burst, border (edge) or picture. Alongside it the block drives a field flag, a one-clock strobe at the start of every picture line, and a pixel-enable that is high exactly while picture samples are due.

The line structure is fixed by parameters whose defaults give standard timing. Three register inputs set the frame shape:
- the number of picture lines per frame,
- the width of the left border,
- the picture width.

The blank lines above and below each field are derived from the picture line count with fixed rounding rules, so every frame keeps 525 lines. The configuration inputs are captured once per frame. This lets software change them at any time without tearing a frame.

Top module: `ntsc_frame_timer`

## Requirements
- R1: A full line lasts LINE_CLKS reference clocks (default 3640). A vertical-interval pulse or a half line lasts LINE_CLKS/2 clocks (default 1820).
- R2: A blank line is made of four runs in order: SYNC for SYNC_CLKS (269), BLANK for S2B_CLKS (35), BURST for BURST_CLKS (144, nine cycles of 16 clocks), then BLANK to the end of the line. Segment codes on seg_o are 0 BLANK, 1 SYNC, 2 BURST, 3 EDGE, 4 ACTIVE.
- R3: A picture line starts with the same first three runs as a blank line. It then gives EDGE for the captured border clocks, ACTIVE for the captured width clocks, and EDGE for the rest of the line. pix_en_o is 1 exactly while seg_o is ACTIVE. act_strobe_o is 1 only on the first clock of each picture line.
- R4: A vertical interval is made of 18 half-line pulses in three groups:
  - six equalizing pulses: SYNC for EQ_LO_CLKS (135), then BLANK for the rest of the half line;
  - six serration pulses: SYNC for half-line minus SERR_HI_CLKS (1551), then BLANK for SERR_HI_CLKS (269);
  - six more equalizing pulses.
- R5: Field 1 (field_o = 0) runs in this order: top blank lines, ceil(L/2) picture lines, bottom blank lines, then a half line that is SYNC for SYNC_CLKS followed by BLANK. It is followed by a vertical interval, during which field_o stays 0.
- R6: Field 2 (field_o = 1) runs in this order: a half line that is BLANK for its whole length, top blank lines, floor(L/2) picture lines, bottom blank lines, then a vertical interval, during which field_o stays 1.
- R7: Each field has floor((484-L)/4)+12 top blank lines.
- R8: Field 1 has floor((482-L)/4) bottom blank lines. Field 2 has that count plus L mod 2. A section whose count is zero is skipped, and the next section follows at once.
- R9: While reset is held, and on the first clock after it is released, the block is at the first clock of the first equalizing pulse of the vertical interval that closes field 2. On that clock seg_o = SYNC, field_o = 1, and both strobes are 0. The full vertical interval then follows.
- R10: The line count L (act_lines_i), border_i and width_i are captured during reset and on the clock edge that begins the vertical interval after field 2. Changes to them at any other time have no effect on the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 16x colour subcarrier |
| rst_n | input | 1 | Synchronous active-low reset |
| act_lines_i | input | LINES_W (9) | Picture lines per frame, L, at most 482 |
| border_i | input | PW (12) | Left border length in clocks |
| width_i | input | PW (12) | Picture width in clocks |
| seg_o | output | 3 | Segment code of the current clock |
| field_o | output | 1 | 0 in field 1, 1 in field 2 |
| act_strobe_o | output | 1 | High on the first clock of a picture line |
| pix_en_o | output | 1 | High while picture samples are due |

## Verification
The assertions assume the following about the inputs:
- act_lines_i never exceeds 482;
- border_i plus width_i never exceeds the clocks left after the burst;
- the timing parameters give a burst end inside a half line.

Under these assumptions a correct design never produces a count of zero top lines, and never moves a line kind in the middle of a line. The stimulus keeps within these bounds by drawing every frame from a table of legal line counts and border/width pairs. Some pairs fill the region after the burst exactly, which leaves a right edge of zero length. The bench uses a compressed line length so that several whole frames fit in the run, while the line-count rules stay at their full values.

// File: rtl/ntsc_tg_pkg.sv
package ntsc_tg_pkg;

   typedef enum logic [2:0] {
      SEG_BLANK  = 3'd0,
      SEG_SYNC   = 3'd1,
      SEG_BURST  = 3'd2,
      SEG_EDGE   = 3'd3,
      SEG_ACTIVE = 3'd4
   } seg_e;

   typedef enum logic [2:0] {
      UK_BLANK  = 3'd0,
      UK_ACTIVE = 3'd1,
      UK_EQ     = 3'd2,
      UK_SERR   = 3'd3,
      UK_HSYNC  = 3'd4,
      UK_HQUIET = 3'd5
   } unit_e;

   typedef enum logic [2:0] {
      PH_EQ1  = 3'd0,
      PH_SERR = 3'd1,
      PH_EQ2  = 3'd2,
      PH_TOP  = 3'd3,
      PH_ACT  = 3'd4,
      PH_BOT  = 3'd5,
      PH_HALF = 3'd6
   } phase_e;

endpackage

// File: rtl/ntsc_blank_calc.sv
module ntsc_blank_calc #(
   parameter int LINES_W   = 9,
   parameter int TOP_BASE  = 484,
   parameter int BOT_BASE  = 482,
   parameter int TOP_EXTRA = 12
) (
   input  logic [LINES_W-1:0] lines_i,
   output logic [LINES_W-1:0] top_n_o,
   output logic [LINES_W-1:0] bot1_n_o,
   output logic [LINES_W-1:0] bot2_n_o,
   output logic [LINES_W-1:0] act1_n_o,
   output logic [LINES_W-1:0] act2_n_o
);
   localparam int CW = LINES_W + 1;

   logic [CW-1:0] l_ext;
   logic [CW-1:0] top_diff;
   logic [CW-1:0] bot_diff;
   logic [CW-1:0] top_q4;
   logic [CW-1:0] bot_q4;

   assign l_ext    = {1'b0, lines_i};
   assign top_diff = CW'(TOP_BASE) - l_ext;
   assign bot_diff = CW'(BOT_BASE) - l_ext;
   assign top_q4   = top_diff >> 2;
   assign bot_q4   = bot_diff >> 2;

   assign top_n_o  = LINES_W'(top_q4) + LINES_W'(TOP_EXTRA);
   assign bot1_n_o = LINES_W'(bot_q4);
   assign bot2_n_o = LINES_W'(bot_q4) + {{(LINES_W-1){1'b0}}, lines_i[0]};
   assign act2_n_o = lines_i >> 1;
   assign act1_n_o = lines_i - (lines_i >> 1);

endmodule

// File: rtl/ntsc_hseg.sv
module ntsc_hseg
   import ntsc_tg_pkg::*;
#(
   parameter int LINE_CLKS    = 3640,
   parameter int SYNC_CLKS    = 269,
   parameter int S2B_CLKS     = 35,
   parameter int BURST_CLKS   = 144,
   parameter int EQ_LO_CLKS   = 135,
   parameter int SERR_HI_CLKS = 269,
   parameter int PW           = $clog2(LINE_CLKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  unit_e         kind_i,
   input  logic [PW-1:0] border_i,
   input  logic [PW-1:0] width_i,
   output logic          unit_end_o,
   output logic          line_start_o,
   output seg_e          seg_o
);
   localparam int HALF_CLKS = LINE_CLKS / 2;
   localparam int XW        = PW + 1;
   localparam logic [XW-1:0] END_SYNC  = XW'(SYNC_CLKS);
   localparam logic [XW-1:0] END_S2B   = XW'(SYNC_CLKS + S2B_CLKS);
   localparam logic [XW-1:0] END_BURST = XW'(SYNC_CLKS + S2B_CLKS + BURST_CLKS);
   localparam logic [XW-1:0] END_EQLO  = XW'(EQ_LO_CLKS);
   localparam logic [XW-1:0] END_SERR  = XW'(HALF_CLKS - SERR_HI_CLKS);
   localparam logic [PW-1:0] LAST_FULL = PW'(LINE_CLKS - 1);
   localparam logic [PW-1:0] LAST_HALF = PW'(HALF_CLKS - 1);

   logic [PW-1:0] pos_q;
   logic [PW-1:0] last_pos;
   logic [XW-1:0] pos_x;
   logic [XW-1:0] end_left;
   logic [XW-1:0] end_pic;
   logic          full_kind;
   seg_e          lead_seg;

   assign full_kind  = (kind_i == UK_BLANK) || (kind_i == UK_ACTIVE);
   assign last_pos   = full_kind ? LAST_FULL : LAST_HALF;
   assign unit_end_o = (pos_q == last_pos);
   assign line_start_o = (pos_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (unit_end_o) begin
         pos_q <= '0;
      end else begin
         pos_q <= pos_q + 1'b1;
      end
   end

   assign pos_x    = {1'b0, pos_q};
   assign end_left = END_BURST + {1'b0, border_i};
   assign end_pic  = end_left + {1'b0, width_i};

   always_comb begin
      if (pos_x < END_SYNC) begin
         lead_seg = SEG_SYNC;
      end else if (pos_x < END_S2B) begin
         lead_seg = SEG_BLANK;
      end else begin
         lead_seg = SEG_BURST;
      end
   end

   always_comb begin
      seg_o = SEG_BLANK;
      unique case (kind_i)
         UK_BLANK: begin
            seg_o = (pos_x < END_BURST) ? lead_seg : SEG_BLANK;
         end
         UK_ACTIVE: begin
            if (pos_x < END_BURST) begin
               seg_o = lead_seg;
            end else if (pos_x < end_left) begin
               seg_o = SEG_EDGE;
            end else if (pos_x < end_pic) begin
               seg_o = SEG_ACTIVE;
            end else begin
               seg_o = SEG_EDGE;
            end
         end
         UK_EQ:     seg_o = (pos_x < END_EQLO) ? SEG_SYNC : SEG_BLANK;
         UK_SERR:   seg_o = (pos_x < END_SERR) ? SEG_SYNC : SEG_BLANK;
         UK_HSYNC:  seg_o = (pos_x < END_SYNC) ? SEG_SYNC : SEG_BLANK;
         UK_HQUIET: seg_o = SEG_BLANK;
         default:   seg_o = SEG_BLANK;
      endcase
   end

   // half-length kinds never see a position past the half line (R1)
   p_half_unit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_kind) |-> (pos_q < PW'(HALF_CLKS)));

   // a new unit always begins at position zero (R1)
   p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      unit_end_o |=> (pos_q == '0));

endmodule

// File: rtl/ntsc_vseq.sv
module ntsc_vseq
   import ntsc_tg_pkg::*;
#(
   parameter int LINES_W    = 9,
   parameter int MAX_ACTIVE = 482,
   parameter int VI_PULSES  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               unit_end_i,
   input  logic [LINES_W-1:0] lines_i,
   output phase_e             phase_o,
   output logic               field_o,
   output unit_e              kind_o,
   output logic               cfg_take_o
);
   localparam logic [LINES_W-1:0] VI_LAST = LINES_W'(VI_PULSES - 1);

   phase_e             phase_q, phase_d;
   logic               field_q, field_d;
   logic [LINES_W-1:0] remain_q, remain_d;
   logic [LINES_W-1:0] lines_q;
   logic [LINES_W-1:0] top_n, bot1_n, bot2_n, act1_n, act2_n;
   logic [LINES_W-1:0] act_n, bot_n;
   logic               go_act, go_bot, go_end, take;

   ntsc_blank_calc #(.LINES_W(LINES_W)) i_calc (
      .lines_i  (lines_q),
      .top_n_o  (top_n),
      .bot1_n_o (bot1_n),
      .bot2_n_o (bot2_n),
      .act1_n_o (act1_n),
      .act2_n_o (act2_n)
   );

   assign act_n = field_q ? act2_n : act1_n;
   assign bot_n = field_q ? bot2_n : bot1_n;

   always_comb begin
      phase_d  = phase_q;
      field_d  = field_q;
      remain_d = remain_q;
      go_act   = 1'b0;
      go_bot   = 1'b0;
      go_end   = 1'b0;
      take     = 1'b0;
      if (unit_end_i) begin
         if (remain_q != '0) begin
            remain_d = remain_q - 1'b1;
         end else begin
            unique case (phase_q)
               PH_EQ1: begin
                  phase_d  = PH_SERR;
                  remain_d = VI_LAST;
               end
               PH_SERR: begin
                  phase_d  = PH_EQ2;
                  remain_d = VI_LAST;
               end
               PH_EQ2: begin
                  if (field_q) begin
                     field_d  = 1'b0;
                     phase_d  = PH_TOP;
                     remain_d = top_n - 1'b1;
                  end else begin
                     field_d  = 1'b1;
                     phase_d  = PH_HALF;
                     remain_d = '0;
                  end
               end
               PH_HALF: begin
                  if (field_q) begin
                     phase_d  = PH_TOP;
                     remain_d = top_n - 1'b1;
                  end else begin
                     phase_d  = PH_EQ1;
                     remain_d = VI_LAST;
                  end
               end
               PH_TOP:  go_act = 1'b1;
               PH_ACT:  go_bot = 1'b1;
               PH_BOT:  go_end = 1'b1;
               default: phase_d = PH_EQ1;
            endcase
            if (go_act) begin
               if (act_n != '0) begin
                  phase_d  = PH_ACT;
                  remain_d = act_n - 1'b1;
               end else begin
                  go_bot = 1'b1;
               end
            end
            if (go_bot) begin
               if (bot_n != '0) begin
                  phase_d  = PH_BOT;
                  remain_d = bot_n - 1'b1;
               end else begin
                  go_end = 1'b1;
               end
            end
            if (go_end) begin
               if (field_q) begin
                  phase_d  = PH_EQ1;
                  remain_d = VI_LAST;
                  take     = 1'b1;
               end else begin
                  phase_d  = PH_HALF;
                  remain_d = '0;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_EQ1;
         field_q  <= 1'b1;
         remain_q <= VI_LAST;
         lines_q  <= lines_i;
      end else begin
         phase_q  <= phase_d;
         field_q  <= field_d;
         remain_q <= remain_d;
         if (take) begin
            lines_q <= lines_i;
         end
      end
   end

   always_comb begin
      unique case (phase_q)
         PH_EQ1, PH_EQ2: kind_o = UK_EQ;
         PH_SERR:        kind_o = UK_SERR;
         PH_ACT:         kind_o = UK_ACTIVE;
         PH_HALF:        kind_o = field_q ? UK_HQUIET : UK_HSYNC;
         default:        kind_o = UK_BLANK;
      endcase
   end

   assign phase_o    = phase_q;
   assign field_o    = field_q;
   assign cfg_take_o = take;

   // the phase moves only at the end of a line or pulse (R5)
   p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_end_i) |=> $stable(phase_q));

   // the field flag flips only on leaving the vertical interval (R6)
   p_field_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_EQ2) |=> $stable(field_q));

   // the captured line count stays in the legal range (R7)
   p_lines_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lines_q <= LINES_W'(MAX_ACTIVE));

   // the top section is never empty (R7)
   p_top_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      top_n != '0);

   // a field-1 bottom section with a zero count is never entered (R8)
   p_skip_bot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_BOT && !field_q) |-> (bot1_n != '0));

endmodule

// File: rtl/ntsc_frame_timer.sv
module ntsc_frame_timer
   import ntsc_tg_pkg::*;
#(
   parameter int LINE_CLKS    = 3640,
   parameter int SYNC_CLKS    = 269,
   parameter int S2B_CLKS     = 35,
   parameter int BURST_CLKS   = 144,
   parameter int EQ_LO_CLKS   = 135,
   parameter int SERR_HI_CLKS = 269,
   parameter int VI_PULSES    = 6,
   parameter int LINES_W      = 9,
   parameter int MAX_ACTIVE   = 482,
   parameter bit OUT_REG      = 1'b0,
   parameter int PW           = $clog2(LINE_CLKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LINES_W-1:0] act_lines_i,
   input  logic [PW-1:0]      border_i,
   input  logic [PW-1:0]      width_i,
   output logic [2:0]         seg_o,
   output logic               field_o,
   output logic               act_strobe_o,
   output logic               pix_en_o
);
   logic [PW-1:0] border_q, width_q;
   logic          unit_end, line_start, cfg_take, field_c;
   phase_e        phase;
   unit_e         kind;
   seg_e          seg_c;
   logic          strobe_c, pix_c;

   ntsc_vseq #(
      .LINES_W    (LINES_W),
      .MAX_ACTIVE (MAX_ACTIVE),
      .VI_PULSES  (VI_PULSES)
   ) i_vseq (
      .clk        (clk),
      .rst_n      (rst_n),
      .unit_end_i (unit_end),
      .lines_i    (act_lines_i),
      .phase_o    (phase),
      .field_o    (field_c),
      .kind_o     (kind),
      .cfg_take_o (cfg_take)
   );

   ntsc_hseg #(
      .LINE_CLKS    (LINE_CLKS),
      .SYNC_CLKS    (SYNC_CLKS),
      .S2B_CLKS     (S2B_CLKS),
      .BURST_CLKS   (BURST_CLKS),
      .EQ_LO_CLKS   (EQ_LO_CLKS),
      .SERR_HI_CLKS (SERR_HI_CLKS),
      .PW           (PW)
   ) i_hseg (
      .clk          (clk),
      .rst_n        (rst_n),
      .kind_i       (kind),
      .border_i     (border_q),
      .width_i      (width_q),
      .unit_end_o   (unit_end),
      .line_start_o (line_start),
      .seg_o        (seg_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         border_q <= border_i;
         width_q  <= width_i;
      end else if (cfg_take) begin
         border_q <= border_i;
         width_q  <= width_i;
      end
   end

   assign strobe_c = line_start && (kind == UK_ACTIVE);
   assign pix_c    = (seg_c == SEG_ACTIVE);

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               seg_o        <= SEG_SYNC;
               field_o      <= 1'b1;
               act_strobe_o <= 1'b0;
               pix_en_o     <= 1'b0;
            end else begin
               seg_o        <= seg_c;
               field_o      <= field_c;
               act_strobe_o <= strobe_c;
               pix_en_o     <= pix_c;
            end
         end
      end else begin : g_out_comb
         assign seg_o        = seg_c;
         assign field_o      = field_c;
         assign act_strobe_o = strobe_c;
         assign pix_en_o     = pix_c;
      end
   endgenerate

   // picture samples only appear inside picture lines (R3)
   p_pix_in_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_c |-> (phase == PH_ACT));

   // the line strobe is a single-clock pulse (R3)
   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_c |=> !strobe_c);

   // every vertical-interval pulse opens with sync (R4)
   p_vi_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && (kind == UK_EQ || kind == UK_SERR)) |-> (seg_c == SEG_SYNC));

   // border and width move only when the frame configuration is taken (R10)
   p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_take) |=> ($stable(border_q) && $stable(width_q)));

endmodule

// File: tb/test_ntsc_frame_timer.sv
module test_ntsc_frame_timer;

   localparam int LINE  = 40;
   localparam int HALF  = LINE / 2;
   localparam int SYNC  = 4;
   localparam int S2B   = 2;
   localparam int BURST = 4;
   localparam int EQLO  = 2;
   localparam int SERRH = 4;
   localparam int POST  = LINE - SYNC - S2B - BURST;
   localparam int PW    = $clog2(LINE);
   localparam int NTBL  = 6;

   // each entry: {line count L (9), border (8), width (8)}
   localparam logic [24:0] TBL [NTBL] = '{
      {9'd480, 8'd5,  8'd20},
      {9'd481, 8'd3,  8'd25},
      {9'd482, 8'd1,  8'd28},
      {9'd1,   8'd10, 8'd10},
      {9'd243, 8'd6,  8'd24},
      {9'd100, 8'd2,  8'd27}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [8:0]    act_lines;
   logic [PW-1:0] border, width;
   logic [2:0]    seg_o;
   logic          field_o, act_strobe_o, pix_en_o;
   logic          exp_field;
   int            checks = 0;
   int            errors = 0;

   always #4 clk = ~clk;

   ntsc_frame_timer #(
      .LINE_CLKS    (LINE),
      .SYNC_CLKS    (SYNC),
      .S2B_CLKS     (S2B),
      .BURST_CLKS   (BURST),
      .EQ_LO_CLKS   (EQLO),
      .SERR_HI_CLKS (SERRH)
   ) i_ntsc_frame_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_lines_i  (act_lines),
      .border_i     (border),
      .width_i      (width),
      .seg_o        (seg_o),
      .field_o      (field_o),
      .act_strobe_o (act_strobe_o),
      .pix_en_o     (pix_en_o)
   );

   // compare one run of identical segment clocks, one check per run
   task automatic run(input logic [2:0] s, input int len, input string tag,
                      input logic strobe_first);
      logic       bad = 1'b0;
      logic [5:0] act_v = '0;
      logic [5:0] exp_v = '0;
      for (int k = 0; k < len; k++) begin
         logic [5:0] e;
         logic [5:0] a;
         e = {s, exp_field, (s == 3'd4), (strobe_first && k == 0)};
         a = {seg_o, field_o, pix_en_o, act_strobe_o};
         if (a !== e && !bad) begin
            bad   = 1'b1;
            act_v = a;
            exp_v = e;
         end
         @(negedge clk);
      end
      if (len > 0) begin
         checks++;
         if (bad) begin
            errors++;
            $display("FAIL %s seg/field/pix/strobe actual %b expected %b", tag, act_v, exp_v);
         end
      end
   endtask

   task automatic blank_line(input string tag);
      run(3'd1, SYNC, tag, 1'b0);
      run(3'd0, S2B, tag, 1'b0);
      run(3'd2, BURST, tag, 1'b0);
      run(3'd0, POST, tag, 1'b0);
   endtask

   task automatic pic_line(input string tag, input int bd, input int w);
      run(3'd1, SYNC, tag, 1'b1);
      run(3'd0, S2B, tag, 1'b0);
      run(3'd2, BURST, tag, 1'b0);
      run(3'd3, bd, tag, 1'b0);
      run(3'd4, w, tag, 1'b0);
      run(3'd3, POST - bd - w, tag, 1'b0);
   endtask

   task automatic vi(input string tag);
      for (int p = 0; p < 6; p++) begin
         run(3'd1, EQLO, tag, 1'b0);
         run(3'd0, HALF - EQLO, tag, 1'b0);
      end
      for (int p = 0; p < 6; p++) begin
         run(3'd1, HALF - SERRH, "R4", 1'b0);
         run(3'd0, SERRH, "R4", 1'b0);
      end
      for (int p = 0; p < 6; p++) begin
         run(3'd1, EQLO, "R4", 1'b0);
         run(3'd0, HALF - EQLO, "R4", 1'b0);
      end
   endtask

   task automatic frame(input int idx);
      int l, bd, w, t, b1, b2, a1, a2, nx;
      l  = int'(TBL[idx][24:16]);
      bd = int'(TBL[idx][15:8]);
      w  = int'(TBL[idx][7:0]);
      t  = (484 - l) / 4 + 12;
      b1 = (482 - l) / 4;
      b2 = b1 + (l % 2);
      a1 = (l + 1) / 2;
      a2 = l / 2;
      nx = (idx + 1 < NTBL) ? idx + 1 : idx;
      // field 1
      exp_field = 1'b0;
      if (idx == 2) begin
         act_lines = 9'd7;
         border    = PW'(2);
         width     = PW'(2);
      end
      for (int n = 0; n < t; n++) blank_line("R2");
      for (int n = 0; n < a1; n++) pic_line(idx == 2 ? "R10" : "R3", bd, w);
      for (int n = 0; n < b1; n++) blank_line("R8");
      run(3'd1, SYNC, (b1 == 0) ? "R8" : "R5", 1'b0);
      run(3'd0, HALF - SYNC, "R5", 1'b0);
      vi("R5");
      // field 2
      exp_field = 1'b1;
      run(3'd0, HALF, "R6", 1'b0);
      act_lines = TBL[nx][24:16];
      border    = PW'(TBL[nx][15:8]);
      width     = PW'(TBL[nx][7:0]);
      for (int n = 0; n < t; n++) blank_line("R7");
      for (int n = 0; n < a2; n++) pic_line(idx == 2 ? "R10" : "R3", bd, w);
      for (int n = 0; n < b2; n++) blank_line("R8");
      vi((a2 == 0 || b2 == 0) ? "R8" : "R6");
   endtask

   task automatic reset_state_check();
      checks++;
      if ({seg_o, field_o, pix_en_o, act_strobe_o} !== 6'b001_1_0_0) begin
         errors++;
         $display("FAIL R9 reset state actual %b expected %b",
                  {seg_o, field_o, pix_en_o, act_strobe_o}, 6'b001100);
      end
   endtask

   initial begin
      rst_n     = 1'b0;
      act_lines = TBL[0][24:16];
      border    = PW'(TBL[0][15:8]);
      width     = PW'(TBL[0][7:0]);
      exp_field = 1'b1;
      repeat (3) @(negedge clk);
      reset_state_check();
      rst_n = 1'b1;
      vi("R9");
      for (int i = 0; i < NTBL; i++) begin
         frame(i);
      end
      // directed: reset in the middle of a field, then line lengths
      repeat (37) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      reset_state_check();
      rst_n     = 1'b1;
      exp_field = 1'b1;
      vi("R9");
      exp_field = 1'b0;
      blank_line("R1");
      blank_line("R1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule